// File: doc/BRIEF.md
# I2C Slave Address Recognizer

This block handles the address phase of a slave on a two-wire serial bus. It runs on a fast system clock and oversamples the clock line (SCL) and the data line (SDA). From these samples it finds START, repeated START and STOP conditions. After each START it shifts in one byte. The byte holds a 7-bit calling address, most significant bit first, followed by a direction bit. When the calling address equals the programmed own address, the block pulls SDA low for the ninth clock of the byte. It also tells downstream logic about the match with a one-cycle strobe, the direction bit and a general-call flag.

An all-zero calling address is not treated as a broadcast. It is acknowledged only when the programmed own address is also all zeros. After the address byte, the block stays silent until the next START or STOP. The block is held inactive while the device acts as a bus master. SDA is open-drain: the block only ever supplies an enable that pulls the line low.

Top module: `i2c_addr_recognizer`

## Requirements
- R1: During and right after a synchronous active-low reset, `sda_drive_low` and `addr_match` are 0.
- R2: After a START, the block samples SDA on each SCL rising edge, most significant bit first. The first seven bits form the calling address and the eighth bit is the direction bit (1 = read). When the calling address equals `own_addr`, `sda_drive_low` is 1 throughout the high phase of the ninth SCL clock.
- R3: On a match, `addr_match` pulses high for exactly one system clock per address byte. In that cycle `match_rw` carries the received direction bit.
- R4: When the calling address differs from `own_addr`, `sda_drive_low` stays 0 and no strobe is issued. The rest of the transfer up to the next START or STOP is ignored, even if a later byte equals the own address.
- R5: A calling address of 0000000 is acknowledged only when `own_addr` is 0000000. In that case `match_gcall` is 1 together with the strobe. For any other match, `match_gcall` is 0.
- R6: A repeated START, sent without a STOP, restarts address reception. A matching address that follows it is acknowledged even if the previous address did not match.
- R7: A STOP (SDA rising while SCL is high) returns the block to idle. Bytes clocked in after it without a new START are not acknowledged.
- R8: The acknowledge drive is released on the SCL falling edge that ends the ninth clock. `sda_drive_low` changes only while the synchronized SCL is low.
- R9: While `master_active` is 1, the block never drives SDA and never asserts `addr_match`, even for a matching address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| master_active | input | 1 | Device is acting as a bus master; disables the slave |
| own_addr | input | 7 | Programmed 7-bit own address |
| scl_in | input | 1 | SCL as seen on the pin |
| sda_in | input | 1 | SDA as seen on the pin |
| sda_drive_low | output | 1 | Open-drain enable; 1 pulls SDA low |
| addr_match | output | 1 | One-cycle strobe on an acknowledged address |
| match_rw | output | 1 | Direction bit of the matched address (1 = read) |
| match_gcall | output | 1 | The matched address was all zeros |

## Verification
A wrong bit count or a bad shift register shows up at the ninth SCL clock of the very first byte. There the acknowledge appears on a non-matching address, or is missing on a matching one. A wrong direction bit shows in `match_rw` in that same strobe cycle. A recognizer stuck outside idle shows up after a STOP or a non-match. It acknowledges a byte that was clocked in without a START, one byte time later. A late release of the acknowledge shows within half an SCL period after the ninth falling edge.

// File: rtl/i2c_addr_pkg.sv
// Shared types and constants for the slave address recognizer.
package i2c_addr_pkg;
    localparam int ADDR_W = 7;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // waiting for START
        ST_ADDR = 2'd1,   // shifting address byte
        ST_ACK  = 2'd2,   // holding SDA low for the ninth clock
        ST_SKIP = 2'd3    // rest of transfer ignored
    } rcv_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
// Synchronizes one asynchronous bus line into the system clock domain and
// flags its edges. Assumes the line idles high (bus released), so every
// stage resets to 1.
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic level,
    output logic rose,
    output logic fell
);
    logic [STAGES-1:0] chain;
    logic              prev;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // first flop samples the raw pin
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= 1'b1;
                    else        chain[0] <= line_in;
                end
            end else begin : g_next
                // later flops settle metastability
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= 1'b1;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    // previous synchronized value for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b1;
        else        prev <= chain[STAGES-1];
    end

    assign level = chain[STAGES-1];
    assign rose  = level & ~prev;
    assign fell  = ~level & prev;
endmodule

// File: rtl/i2c_bus_events.sv
// Turns synchronized SCL/SDA levels and edges into bus events: SCL edges,
// START and STOP. Assumes both lines pass through equal synchronizer depth,
// so their relative order is kept. An SDA edge only counts as a condition
// when SCL is high and was not rising in the same cycle.
module i2c_bus_events (
    input  logic scl_level,
    input  logic scl_rose,
    input  logic scl_fell,
    input  logic sda_rose,
    input  logic sda_fell,
    output logic clk_rise,
    output logic clk_fall,
    output logic start_cond,
    output logic stop_cond
);
    logic scl_steady_high;

    // classify SDA edges against a steady-high SCL
    always_comb begin
        scl_steady_high = scl_level & ~scl_rose;
        start_cond      = scl_steady_high & sda_fell;
        stop_cond       = scl_steady_high & sda_rose;
        clk_rise        = scl_rose;
        clk_fall        = scl_fell;
    end
endmodule

// File: rtl/i2c_addr_fsm.sv
// Address-phase state machine. It shifts in the address byte, compares the
// address with own_addr, drives the acknowledge and issues the match strobe.
// Assumes the bus events are single-cycle pulses in the system clock domain.
// Priority: master_active, then STOP, then START, then normal sequencing.
module i2c_addr_fsm
    import i2c_addr_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          master_active,
    input  logic [AW-1:0] own_addr,
    input  logic          sda_level,
    input  logic          clk_rise,
    input  logic          clk_fall,
    input  logic          start_cond,
    input  logic          stop_cond,
    output logic          drive_low,
    output logic          match_stb,
    output logic          match_rw,
    output logic          match_gcall
);
    localparam int FRAME_BITS = AW + 1;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS);

    rcv_state_t        state;
    logic [CNT_W-1:0]  bit_cnt;
    logic [AW:0]       shreg;
    logic              addr_hit;
    logic              byte_done;

    // compare the received calling address with the programmed one
    always_comb begin
        addr_hit  = (shreg[AW:1] == own_addr);
        byte_done = (bit_cnt == LAST_BIT);
    end

    // sequencing of the address phase and the acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            bit_cnt     <= '0;
            shreg       <= '0;
            drive_low   <= 1'b0;
            match_stb   <= 1'b0;
            match_rw    <= 1'b0;
            match_gcall <= 1'b0;
        end else begin
            match_stb <= 1'b0;
            if (master_active || stop_cond) begin
                state     <= ST_IDLE;
                drive_low <= 1'b0;
            end else if (start_cond) begin
                state     <= ST_ADDR;
                bit_cnt   <= '0;
                drive_low <= 1'b0;
            end else begin
                unique case (state)
                    ST_ADDR: begin
                        if (clk_rise && !byte_done) begin
                            shreg   <= {shreg[AW-1:0], sda_level};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (clk_fall && byte_done) begin
                            if (addr_hit) begin
                                state       <= ST_ACK;
                                drive_low   <= 1'b1;
                                match_stb   <= 1'b1;
                                match_rw    <= shreg[0];
                                match_gcall <= (shreg[AW:1] == '0);
                            end else begin
                                state <= ST_SKIP;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (clk_fall) begin
                            drive_low <= 1'b0;
                            state     <= ST_SKIP;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_addr_recognizer.sv
// Top of the slave address recognizer: two line synchronizers, the bus
// event decoder and the address state machine. Assumes SCL is slow enough
// that each SCL phase lasts several system clocks.
module i2c_addr_recognizer
    import i2c_addr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_active,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_drive_low,
    output logic              addr_match,
    output logic              match_rw,
    output logic              match_gcall
);
    logic scl_sync, scl_rose, scl_fell;
    logic sda_sync, sda_rose, sda_fell;
    logic clk_rise, clk_fall, start_cond, stop_cond;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .line_in(scl_in),
        .level(scl_sync), .rose(scl_rose), .fell(scl_fell)
    );

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .line_in(sda_in),
        .level(sda_sync), .rose(sda_rose), .fell(sda_fell)
    );

    i2c_bus_events u_events (
        .scl_level(scl_sync), .scl_rose(scl_rose), .scl_fell(scl_fell),
        .sda_rose(sda_rose), .sda_fell(sda_fell),
        .clk_rise(clk_rise), .clk_fall(clk_fall),
        .start_cond(start_cond), .stop_cond(stop_cond)
    );

    i2c_addr_fsm #(.AW(ADDR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .master_active(master_active),
        .own_addr(own_addr), .sda_level(sda_sync),
        .clk_rise(clk_rise), .clk_fall(clk_fall),
        .start_cond(start_cond), .stop_cond(stop_cond),
        .drive_low(sda_drive_low), .match_stb(addr_match),
        .match_rw(match_rw), .match_gcall(match_gcall)
    );
endmodule

// File: rtl/i2c_addr_recognizer_checker.sv
// Protocol checks on the recognizer ports and its synchronized SCL.
module i2c_addr_recognizer_checker
    import i2c_addr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              master_active,
    input logic [ADDR_W-1:0] own_addr,
    input logic              scl_sync,
    input logic              sda_drive_low,
    input logic              addr_match,
    input logic              match_gcall
);
    // R1: reset clears the outputs
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!sda_drive_low && !addr_match));

    // R3: strobe lasts one cycle
    a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        addr_match |=> !addr_match);

    // R2: strobe comes together with the start of the acknowledge
    a_r2_strobe_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
        addr_match |-> sda_drive_low);

    // R5: general-call flag only with an all-zero own address
    a_r5_gcall_zero_own: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_match && match_gcall) |-> (own_addr == '0));

    // R8: drive changes only while SCL is low
    a_r8_drive_on_low_scl: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_drive_low) || $fell(sda_drive_low)) |-> !scl_sync);

    // R9: master mode keeps the slave silent
    a_r9_master_silent: assert property (@(posedge clk) disable iff (!rst_n)
        master_active |=> (!sda_drive_low && !addr_match));
endmodule

bind i2c_addr_recognizer i2c_addr_recognizer_checker u_checker (
    .clk(clk), .rst_n(rst_n), .master_active(master_active),
    .own_addr(own_addr), .scl_sync(scl_sync),
    .sda_drive_low(sda_drive_low), .addr_match(addr_match),
    .match_gcall(match_gcall)
);

// File: tb/test_i2c_addr_recognizer.sv
module test_i2c_addr_recognizer;
    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       master_active = 1'b0;
    logic [6:0] own_addr = 7'h00;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_bus;
    logic       sda_drive_low, addr_match, match_rw, match_gcall;

    int checks = 0;
    int errors = 0;
    int strobes = 0;
    logic cap_rw = 1'b0;
    logic cap_gc = 1'b0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;  // 200 MHz

    assign sda_bus = sda_m & ~sda_drive_low;  // wired-AND bus

    i2c_addr_recognizer i_i2c_addr_recognizer (
        .clk(clk), .rst_n(rst_n), .master_active(master_active),
        .own_addr(own_addr), .scl_in(scl_m), .sda_in(sda_bus),
        .sda_drive_low(sda_drive_low), .addr_match(addr_match),
        .match_rw(match_rw), .match_gcall(match_gcall)
    );

    // count strobes and capture their side outputs
    always @(posedge clk) begin
        if (rst_n && addr_match) begin
            strobes <= strobes + 1;
            cap_rw  <= match_rw;
            cap_gc  <= match_gcall;
        end
    end

    function automatic bit exp_ack(input logic [6:0] own, input logic [6:0] call, input bit master);
        return !master && (own == call);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_start;  // also works as repeated START
        sda_m = 1'b1; wait_clk(HALF);
        scl_m = 1'b1; wait_clk(HALF);
        sda_m = 1'b0; wait_clk(HALF);
        scl_m = 1'b0; wait_clk(HALF);
    endtask

    task automatic do_stop;
        sda_m = 1'b0; wait_clk(HALF);
        scl_m = 1'b1; wait_clk(HALF);
        sda_m = 1'b1; wait_clk(HALF);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b;    wait_clk(HALF);
        scl_m = 1'b1; wait_clk(HALF);
        scl_m = 1'b0;
    endtask

    // sends one byte and the ninth clock; reports ack and strobes seen
    task automatic send_byte(input logic [7:0] b, input bit chk_release,
                             output bit acked, output int nstb);
        int s0;
        s0 = strobes;
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; wait_clk(HALF);
        scl_m = 1'b1; wait_clk(HALF / 2);
        acked = sda_drive_low;
        wait_clk(HALF / 2);
        scl_m = 1'b0; wait_clk(HALF - 2);
        if (chk_release)
            chk(sda_drive_low == 1'b0, "R8 release after ninth clock", sda_drive_low, 0);
        wait_clk(2);
        nstb = strobes - s0;
    endtask

    task automatic addr_txn(input logic [6:0] own, input logic [6:0] call,
                            input logic rw, input string tag);
        bit ack; int n; bit e;
        own_addr = own;
        e = exp_ack(own, call, master_active);
        do_start();
        send_byte({call, rw}, e, ack, n);
        chk(ack == e, {tag, " ack"}, ack, e);
        chk(n == (e ? 1 : 0), "R3 strobe count", n, e ? 1 : 0);
        if (e) begin
            chk(cap_rw == rw, "R3 direction bit", cap_rw, rw);
            chk(cap_gc == (call == 0), "R5 general-call flag", cap_gc, call == 0);
        end
        do_stop();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        bit ack; int n;
        void'($urandom(32'd20240611));
        wait_clk(4);
        chk(sda_drive_low == 0 && addr_match == 0, "R1 reset outputs", sda_drive_low, 0);
        rst_n = 1'b1;
        wait_clk(4);
        chk(sda_drive_low == 0 && addr_match == 0, "R1 after reset", sda_drive_low, 0);

        // R2 directed matches, edge values of the address
        addr_txn(7'h5A, 7'h5A, 1'b1, "R2 match read");
        addr_txn(7'h7F, 7'h7F, 1'b0, "R2 match all-ones");
        addr_txn(7'h01, 7'h40, 1'b0, "R4 bit-reversed mismatch");

        // R5 general call
        addr_txn(7'h00, 7'h00, 1'b0, "R5 gcall with zero own");
        addr_txn(7'h22, 7'h00, 1'b0, "R5 gcall with nonzero own");

        // R4 ignore rest after mismatch
        own_addr = 7'h33;
        do_start();
        send_byte({7'h34, 1'b0}, 1'b0, ack, n);
        chk(ack == 0, "R4 mismatch nack", ack, 0);
        send_byte({7'h33, 1'b0}, 1'b0, ack, n);
        chk(ack == 0 && n == 0, "R4 later byte ignored", ack, 0);

        // R6 repeated START after mismatch
        do_start();
        send_byte({7'h33, 1'b1}, 1'b1, ack, n);
        chk(ack == 1 && n == 1, "R6 repeated start match", ack, 1);
        do_stop();

        // R7 STOP returns to idle
        do_start();
        send_byte({7'h33, 1'b0}, 1'b1, ack, n);
        chk(ack == 1, "R7 match before stop", ack, 1);
        do_stop();
        scl_m = 1'b0; wait_clk(HALF);
        send_byte({7'h33, 1'b0}, 1'b0, ack, n);
        chk(ack == 0 && n == 0, "R7 no start after stop", ack, 0);
        scl_m = 1'b1; wait_clk(HALF);
        sda_m = 1'b1; wait_clk(HALF);

        // R9 master mode
        master_active = 1'b1;
        addr_txn(7'h33, 7'h33, 1'b0, "R9 master active");
        master_active = 1'b0;

        // R2/R4 random mix
        for (int k = 0; k < 24; k++) begin
            logic [6:0] own, call; logic rw;
            own  = 7'($urandom % 128);
            call = ($urandom % 2) ? own : 7'($urandom % 128);
            rw   = 1'($urandom % 2);
            addr_txn(own, call, rw, "R2 R4 random");
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule